// File: doc/BRIEF.md
# Rotate and Shift Unit with Flag Generation

This block is the bit-rotation and bit-shift datapath of an 8-bit processor core. It is purely combinational. The operand, a 3-bit operation code and the processor's current flag byte go in. The transformed operand and a complete new flag byte come out in the same cycle. Only the carry bit of the incoming flag byte affects the outcome, and only for the two operations that rotate through carry.

Eight operations are provided. Each one moves the operand by one position. A left-moving operation sends the old most significant bit to carry. A right-moving operation sends the old least significant bit to carry. The operations differ only in the bit that fills the vacated position. The surrounding core decodes instructions, fetches operands and writes results back. This unit only computes.

Top module: `rot_shift_unit`

## Requirements
- R1: For every operation code, the subtract flag (flags_out bit 1) and the half-carry flag (flags_out bit 4) are 0.
- R2: Code 0 rotates left circularly: result = {operand[6:0], operand[7]}, and carry (flags_out bit 0) = operand[7].
- R3: Code 1 rotates right circularly: result = {operand[0], operand[7:1]}, and carry = operand[0].
- R4: Code 2 rotates left through carry: result = {operand[6:0], flags_in[0]}, and carry = operand[7].
- R5: Code 3 rotates right through carry: result = {flags_in[0], operand[7:1]}, and carry = operand[0].
- R6: Code 4 shifts left with a 0 entering bit 0. Code 6 shifts left with a 1 entering bit 0. For both codes, carry = operand[7].
- R7: Code 5 shifts right and keeps bit 7 (result = {operand[7], operand[7:1]}). Code 7 shifts right with a 0 entering bit 7. For both codes, carry = operand[0].
- R8: The following flag bits come from the result: sign (bit 7) = result[7], zero (bit 6) = 1 exactly when the result is 0, bit 5 = result[5], and bit 3 = result[3].
- R9: The parity flag (bit 2) is 1 exactly when the result has an even number of one bits.
- R10: flags_in bits 7 to 1 have no effect on result_out or flags_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code, 0 to 7 |
| operand_in | input | 8 | Value to rotate or shift |
| flags_in | input | 8 | Current flag byte; only bit 0 (carry) is used |
| result_out | output | 8 | Rotated or shifted value |
| flags_out | output | 8 | New flag byte |

## Verification
The hardest case to reach is one where a fault is masked by the incoming carry. In the through-carry rotates, a fill taken from the wrong source looks correct whenever that source happens to equal the carry. The stimulus therefore sweeps every operand with both carry values for every code. Each vector is applied a second time with different random values in the unused flag bits, and both sets of outputs must match. This exposes any leak from the bits that should be ignored.

// File: rtl/rsu_pkg.sv
// Package: shared operation codes and flag bit positions for the rotate/shift unit.
// Assumes an 8-bit flag byte with the bit layout used throughout the core.
package rsu_pkg;

    typedef enum logic [2:0] {
        OP_ROL_CIRC  = 3'd0,
        OP_ROR_CIRC  = 3'd1,
        OP_ROL_CARRY = 3'd2,
        OP_ROR_CARRY = 3'd3,
        OP_SHL_ZERO  = 3'd4,
        OP_SHR_KEEP  = 3'd5,
        OP_SHL_ONE   = 3'd6,
        OP_SHR_ZERO  = 3'd7
    } rsu_op_e;

    localparam int FLAG_W   = 8;
    localparam int FB_CARRY = 0;
    localparam int FB_SUB   = 1;
    localparam int FB_PAR   = 2;
    localparam int FB_X3    = 3;
    localparam int FB_HALF  = 4;
    localparam int FB_Y5    = 5;
    localparam int FB_ZERO  = 6;
    localparam int FB_SIGN  = 7;

endpackage

// File: rtl/rsu_shift_core.sv
// Module: one-position rotate/shift datapath.
// Opcode bit 0 selects the direction (0 = left, 1 = right).
// Opcode bits 2:1 select the fill source for the vacated bit.
// Assumes DATA_W >= 2.
module rsu_shift_core
    import rsu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] value,
    input  logic              carry_in,
    output logic [DATA_W-1:0] shifted,
    output logic              carry_out
);
    localparam int MSB = DATA_W - 1;

    logic go_right;
    logic fill_bit;

    // Direction comes from the low opcode bit.
    always_comb go_right = op[0];

    // Fill source: circular, through carry, arithmetic/zero, or a forced constant.
    always_comb begin
        unique case (op)
            OP_ROL_CIRC:  fill_bit = value[MSB];
            OP_ROR_CIRC:  fill_bit = value[0];
            OP_ROL_CARRY: fill_bit = carry_in;
            OP_ROR_CARRY: fill_bit = carry_in;
            OP_SHL_ZERO:  fill_bit = 1'b0;
            OP_SHR_KEEP:  fill_bit = value[MSB];
            OP_SHL_ONE:   fill_bit = 1'b1;
            default:      fill_bit = 1'b0;
        endcase
    end

    // Move the operand one place and insert the fill bit.
    always_comb begin
        if (go_right) shifted = {fill_bit, value[MSB:1]};
        else          shifted = {value[MSB-1:0], fill_bit};
    end

    // The bit that leaves the operand becomes the new carry.
    always_comb carry_out = go_right ? value[0] : value[MSB];

endmodule

// File: rtl/rsu_flag_gen.sv
// Module: builds the output flag byte from the result and the carry out.
// Subtract and half-carry are always cleared.
// Assumes an 8-bit result so that bits 5 and 3 exist.
module rsu_flag_gen
    import rsu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] result,
    input  logic              carry,
    output logic [FLAG_W-1:0] flags
);
    logic is_zero;
    logic even_par;

    // Zero detection and even parity over the whole result.
    always_comb begin
        is_zero  = (result == '0);
        even_par = ~(^result);
    end

    // Place each flag at its bit position.
    always_comb begin
        flags           = '0;
        flags[FB_CARRY] = carry;
        flags[FB_SUB]   = 1'b0;
        flags[FB_PAR]   = even_par;
        flags[FB_X3]    = result[3];
        flags[FB_HALF]  = 1'b0;
        flags[FB_Y5]    = result[5];
        flags[FB_ZERO]  = is_zero;
        flags[FB_SIGN]  = result[DATA_W-1];
    end

endmodule

// File: rtl/rot_shift_unit.sv
// Module: top of the rotate/shift unit. Purely combinational, so it has no
// clock or reset. Only the carry bit of flags_in is consumed; the mask below
// makes that choice explicit.
module rot_shift_unit
    import rsu_pkg::*;
(
    input  logic [2:0] op_sel,
    input  logic [7:0] operand_in,
    input  logic [7:0] flags_in,
    output logic [7:0] result_out,
    output logic [7:0] flags_out
);
    localparam int          DATA_W     = 8;
    localparam logic [7:0]  CARRY_MASK = 8'(1) << FB_CARRY;

    logic              carry_now;
    logic              carry_next;
    logic [DATA_W-1:0] moved;

    // Extract the incoming carry with the mask.
    always_comb carry_now = |(flags_in & CARRY_MASK);

    rsu_shift_core #(.DATA_W(DATA_W)) u_core (
        .op        (op_sel),
        .value     (operand_in),
        .carry_in  (carry_now),
        .shifted   (moved),
        .carry_out (carry_next)
    );

    rsu_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .result (moved),
        .carry  (carry_next),
        .flags  (flags_out)
    );

    // Drive the result port.
    always_comb result_out = moved;

endmodule

// File: rtl/rsu_checker.sv
// Module: property checker for rot_shift_unit, attached with bind.
// The unit is combinational, so the checks are immediate assertions
// evaluated whenever the ports change.
module rsu_checker (
    input logic [2:0] op_sel,
    input logic [7:0] operand_in,
    input logic [7:0] flags_in,
    input logic [7:0] result_out,
    input logic [7:0] flags_out
);
    // Port relations that must hold for every input combination.
    always_comb begin
        AST_NH_CLEAR: assert (flags_out[1] == 1'b0 && flags_out[4] == 1'b0); // R1
        AST_ZERO_FLAG: assert (flags_out[6] == (result_out == 8'h00)); // R8
        AST_SIGN_FLAG: assert (flags_out[7] == result_out[7]); // R8
        AST_PARITY_FLAG: assert (flags_out[2] == ($countones(result_out) % 2 == 0)); // R9
        if (op_sel[0] == 1'b0) begin
            AST_LEFT_BODY: assert (result_out[7:1] == operand_in[6:0]); // R6
            AST_LEFT_CARRY: assert (flags_out[0] == operand_in[7]); // R2
        end else begin
            AST_RIGHT_BODY: assert (result_out[6:0] == operand_in[7:1]); // R7
            AST_RIGHT_CARRY: assert (flags_out[0] == operand_in[0]); // R3
        end
        if (op_sel == 3'd2) begin
            AST_RL_FILL: assert (result_out[0] == flags_in[0]); // R4
        end
        if (op_sel == 3'd3) begin
            AST_RR_FILL: assert (result_out[7] == flags_in[0]); // R5
        end
    end
endmodule

bind rot_shift_unit rsu_checker u_rsu_checker (
    .op_sel     (op_sel),
    .operand_in (operand_in),
    .flags_in   (flags_in),
    .result_out (result_out),
    .flags_out  (flags_out)
);

// File: tb/tb_rot_shift_unit.sv
module tb_rot_shift_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel;
    logic [7:0] operand_in;
    logic [7:0] flags_in;
    logic [7:0] result_out;
    logic [7:0] flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rot_shift_unit dut (
        .op_sel     (op_sel),
        .operand_in (operand_in),
        .flags_in   (flags_in),
        .result_out (result_out),
        .flags_out  (flags_out)
    );

    function automatic string op_tag(int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4, 6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Behavioural reference: integer arithmetic, returns {result, flags}.
    function automatic logic [15:0] ref_model(int op, int v, int cin);
        int r, c, fill, ones, f;
        if (op % 2 == 0) begin
            c = v / 128;
            case (op)
                0: fill = c;
                2: fill = cin;
                4: fill = 0;
                default: fill = 1;
            endcase
            r = (v * 2) % 256 + fill;
        end else begin
            c = v % 2;
            case (op)
                1: fill = c;
                3: fill = cin;
                5: fill = v / 128;
                default: fill = 0;
            endcase
            r = v / 2 + fill * 128;
        end
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) % 2;
        f = c;
        if (ones % 2 == 0) f += 4;
        f += r & 8'h28;
        if (r == 0) f += 64;
        if (r >= 128) f += 128;
        return {r[7:0], f[7:0]};
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] exp;
        logic [7:0]  r_first, f_first;
        op_sel = 3'd0; operand_in = 8'h00; flags_in = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Initial state: code 0 on zero gives zero result, Z and P/V set.
        check("R8", "reset result", result_out, 8'h00);
        check("R9", "reset flags", flags_out, 8'h44);
        for (int op = 0; op < 8; op++) begin
            for (int v = 0; v < 256; v++) begin
                for (int cin = 0; cin < 2; cin++) begin
                    @(posedge clk);
                    op_sel = op[2:0]; operand_in = v[7:0];
                    flags_in = (8'($urandom) & 8'hFE) | 8'(cin);
                    exp = ref_model(op, v, cin);
                    @(negedge clk);
                    check(op_tag(op), "result", result_out, exp[15:8]);
                    check(op_tag(op), "carry", flags_out[0], exp[0]);
                    check("R1", "N/H", {flags_out[4], flags_out[1]}, 0);
                    check("R8", "S/Z/Y/X", flags_out & 8'hE8, exp[7:0] & 8'hE8);
                    check("R9", "parity", flags_out[2], exp[2]);
                    r_first = result_out; f_first = flags_out;
                    @(posedge clk);
                    flags_in = (~flags_in & 8'hFE) | 8'(cin);
                    @(negedge clk);
                    check("R10", "result unchanged", result_out, r_first);
                    check("R10", "flags unchanged", flags_out, f_first);
                end
            end
        end
        // Named corner cases.
        @(posedge clk); op_sel = 3'd6; operand_in = 8'h80; flags_in = 8'h00;
        @(negedge clk);
        check("R6", "SLL 80 result", result_out, 8'h01);
        check("R6", "SLL 80 flags", flags_out, 8'h01);
        @(posedge clk); op_sel = 3'd5; operand_in = 8'h81; flags_in = 8'hFE;
        @(negedge clk);
        check("R7", "SRA 81 result", result_out, 8'hC0);
        check("R7", "SRA 81 flags", flags_out, 8'h85);
        @(posedge clk); op_sel = 3'd3; operand_in = 8'h01; flags_in = 8'h00;
        @(negedge clk);
        check("R5", "RR 01 result", result_out, 8'h00);
        check("R5", "RR 01 flags", flags_out, 8'h45);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule